// File: doc/BRIEF.md
# Spill-Interrupt Call Stack

This block is a small last-in-first-out store, ten words deep and sixteen bits wide, for a processor core. The core uses it for return addresses on call and return, and for saving and restoring the general registers and the flag word. The write pointer is internal and never read or written by software. Each accepted push moves it up by one and each accepted pull moves it down by one.

A push into a full stack or a pull from an empty stack never completes. It raises a dedicated top-priority interrupt request instead. The handler can then copy entries out to a memory stack, or bring them back in, so the on-chip words work as a cache for a deeper stack in memory. The handler reads a depth count and full and empty flags to decide how many words to move, and it clears the request with an acknowledge pulse.

Top module: `call_stack_cache`

## Requirements
- R1: A push with no pull in the same cycle, made while depth is below 10, stores `push_data` on top. Depth then rises by one after the clock edge.
- R2: A pull with no push in the same cycle, made while depth is above 0, places the most recently stored word that has not yet been pulled on `pull_data` one cycle later. Depth then drops by one.
- R3: `depth` gives the number of stored words, from 0 to 10. `full` is 1 exactly when depth is 10, and `empty` is 1 exactly when depth is 0.
- R4: A push at depth 10 sets `fault_irq` on the next cycle. It leaves depth and the stored words unchanged.
- R5: A pull at depth 0 sets `fault_irq` on the next cycle, drives `pull_data` to 0 and leaves depth at 0.
- R6: `fault_irq` stays at 1 until a cycle with `fault_ack` = 1. A push or pull made in that same cycle is evaluated after the clear, so a faulting operation leaves the request at 1.
- R7: Push and pull asserted together are both ignored. Depth, the stored words and `pull_data` stay unchanged, and `clash_err` is 1 for the following cycle only.
- R8: A synchronous reset (`rst` = 1 at a clock edge) sets depth to 0, clears `fault_irq` and `clash_err`, and sets `pull_data` to 0.
- R9: `pull_data` keeps its value in every cycle that has no pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_req | input | 1 | Push strobe for one cycle |
| pull_req | input | 1 | Pull strobe for one cycle |
| push_data | input | 16 | Word to store on a push |
| fault_ack | input | 1 | Clears the fault request |
| pull_data | output | 16 | Word returned by the last pull (registered) |
| depth | output | 4 | Number of stored words, 0 to 10 |
| full | output | 1 | Depth equals 10 |
| empty | output | 1 | Depth equals 0 |
| fault_irq | output | 1 | Stack overflow or underflow request |
| clash_err | output | 1 | One-cycle pulse after a simultaneous push and pull |

## Verification
The assertions check the cycle-to-cycle rules on every cycle:
- depth moves by exactly one on an accepted push or pull;
- a faulting operation raises the request without moving depth;
- an underflow returns zero;
- the request holds until it is acknowledged;
- a clash produces the error pulse and freezes depth.

Only the bench scenarios can show that the stored words come back in the correct last-in order after long random mixes of operations. The same applies to a fault posted in the acknowledge cycle and to reset in the middle of activity. The bench checks these against a reference model of the stack.

// File: rtl/stk_pkg.sv
package stk_pkg;
    // Decoded request for one cycle
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PUSH  = 2'd1,
        OP_PULL  = 2'd2,
        OP_CLASH = 2'd3
    } stk_op_e;

    function automatic stk_op_e decode_op(input logic push, input logic pull);
        return stk_op_e'({pull, push});
    endfunction
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int DEPTH = 10,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pull,
    input  logic             ack,
    output logic             wr_en,
    output logic             rd_en,
    output logic             rd_zero,
    output logic [CNT_W-1:0] wr_idx,
    output logic [CNT_W-1:0] rd_idx,
    output logic [CNT_W-1:0] cnt,
    output logic             is_full,
    output logic             is_empty,
    output logic             irq,
    output logic             err
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             err;
    } ctrl_t;

    ctrl_t   st_d, st_q;
    stk_op_e op;
    logic    fault;

    always_comb begin
        op       = decode_op(push, pull);
        is_full  = (st_q.cnt == TOP);
        is_empty = (st_q.cnt == '0);
        wr_en    = (op == OP_PUSH) && !is_full;
        rd_en    = (op == OP_PULL) && !is_empty;
        rd_zero  = (op == OP_PULL) && is_empty;
        fault    = ((op == OP_PUSH) && is_full) || rd_zero;
        wr_idx   = st_q.cnt;
        rd_idx   = st_q.cnt - CNT_W'(1);

        st_d     = st_q;
        if (wr_en) st_d.cnt = st_q.cnt + CNT_W'(1);
        if (rd_en) st_d.cnt = st_q.cnt - CNT_W'(1);
        // acknowledge clears first, a fault in the same cycle re-posts
        st_d.irq = (st_q.irq && !ack) || fault;
        st_d.err = (op == OP_CLASH);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign irq = st_q.irq;
    assign err = st_q.err;
endmodule

// File: rtl/stk_store.sv
module stk_store #(
    parameter int DEPTH = 10,
    parameter int WIDTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rd_zero,
    input  logic [CNT_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [WIDTH-1:0] word_d, word_q;
        always_comb begin
            word_d = word_q;
            if (wr_en && (wr_idx == CNT_W'(g))) word_d = wr_data;
        end
        always_ff @(posedge clk) begin
            word_q <= word_d;
        end
        assign words[g] = word_q;
    end

    logic [WIDTH-1:0] top_word;
    logic [WIDTH-1:0] dout_d, dout_q;

    always_comb begin
        top_word = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == CNT_W'(i)) top_word = words[i];
        end
        dout_d = dout_q;
        if (rd_en)        dout_d = top_word;
        else if (rd_zero) dout_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) dout_q <= '0;
        else     dout_q <= dout_d;
    end

    assign rd_data = dout_q;
endmodule

// File: rtl/call_stack_cache.sv
module call_stack_cache #(
    parameter int DEPTH = 10,
    parameter int WIDTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             pull_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             fault_ack,
    output logic [WIDTH-1:0] pull_data,
    output logic [CNT_W-1:0] depth,
    output logic             full,
    output logic             empty,
    output logic             fault_irq,
    output logic             clash_err
);
    logic             wr_en, rd_en, rd_zero;
    logic [CNT_W-1:0] wr_idx, rd_idx;

    stk_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .push     (push_req),
        .pull     (pull_req),
        .ack      (fault_ack),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .rd_zero  (rd_zero),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .cnt      (depth),
        .is_full  (full),
        .is_empty (empty),
        .irq      (fault_irq),
        .err      (clash_err)
    );

    stk_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (push_data),
        .rd_en   (rd_en),
        .rd_zero (rd_zero),
        .rd_idx  (rd_idx),
        .rd_data (pull_data)
    );
endmodule

// File: rtl/stk_chk.sv
module stk_chk #(
    parameter int DEPTH = 10,
    parameter int WIDTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             push_req,
    input logic             pull_req,
    input logic             fault_ack,
    input logic [WIDTH-1:0] pull_data,
    input logic [CNT_W-1:0] depth,
    input logic             full,
    input logic             empty,
    input logic             fault_irq,
    input logic             clash_err
);
    assert_depth_range_R3: assert property (@(posedge clk) disable iff (rst)
        depth <= CNT_W'(DEPTH));

    assert_push_grows_R1: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pull_req && !full) |=> (depth == $past(depth) + CNT_W'(1)));

    assert_pull_shrinks_R2: assert property (@(posedge clk) disable iff (rst)
        (pull_req && !push_req && !empty) |=> (depth == $past(depth) - CNT_W'(1)));

    assert_overflow_posts_R4: assert property (@(posedge clk) disable iff (rst)
        (push_req && !pull_req && full) |=> (fault_irq && $stable(depth)));

    assert_underflow_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (pull_req && !push_req && empty) |=> (fault_irq && pull_data == '0 && depth == '0));

    assert_irq_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (fault_irq && !fault_ack) |=> fault_irq);

    assert_clash_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (push_req && pull_req) |=> (clash_err && $stable(depth) && $stable(pull_data)));

    assert_dout_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !pull_req |=> $stable(pull_data));
endmodule

bind call_stack_cache stk_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .push_req  (push_req),
    .pull_req  (pull_req),
    .fault_ack (fault_ack),
    .pull_data (pull_data),
    .depth     (depth),
    .full      (full),
    .empty     (empty),
    .fault_irq (fault_irq),
    .clash_err (clash_err)
);

// File: tb/tb_call_stack_cache.sv
`timescale 1ns/1ps
module tb_call_stack_cache;
    localparam int D = 10;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_req = 1'b0, pull_req = 1'b0, fault_ack = 1'b0;
    logic [W-1:0]  push_data = '0;
    logic [W-1:0]  pull_data;
    logic [3:0]    depth;
    logic          full, empty, fault_irq, clash_err;

    int total = 0;
    int bad = 0;

    // reference model
    logic [W-1:0] m_mem [D];
    int           m_cnt = 0;
    logic         m_irq = 1'b0, m_err = 1'b0;
    logic [W-1:0] m_dout = '0;

    always #2 clk = ~clk;

    call_stack_cache dut (
        .clk(clk), .rst(rst), .push_req(push_req), .pull_req(pull_req),
        .push_data(push_data), .fault_ack(fault_ack), .pull_data(pull_data),
        .depth(depth), .full(full), .empty(empty), .fault_irq(fault_irq),
        .clash_err(clash_err)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "pull_data", int'(pull_data), int'(m_dout));
        check("R3", "depth", int'(depth), m_cnt);
        check("R3", "full", int'(full), int'(m_cnt == D));
        check("R3", "empty", int'(empty), int'(m_cnt == 0));
        check(tag, "fault_irq", int'(fault_irq), int'(m_irq));
        check("R7", "clash_err", int'(clash_err), int'(m_err));
    endtask

    // one cycle: drive at negedge, update model at the edge, compare at next negedge
    task automatic step(input logic p, input logic q, input logic [W-1:0] d, input logic a);
        string tag;
        logic  fault;
        push_req = p; pull_req = q; push_data = d; fault_ack = a;
        @(posedge clk);
        fault = 1'b0;
        m_err = p && q;
        if (p && q) tag = "R7";
        else if (p) begin
            if (m_cnt == D) begin fault = 1'b1; tag = "R4"; end
            else begin m_mem[m_cnt] = d; m_cnt++; tag = "R1"; end
        end else if (q) begin
            if (m_cnt == 0) begin fault = 1'b1; m_dout = '0; tag = "R5"; end
            else begin m_cnt--; m_dout = m_mem[m_cnt]; tag = "R2"; end
        end else tag = a ? "R6" : "R9";
        m_irq = (m_irq && !a) || fault;
        @(negedge clk);
        push_req = 1'b0; pull_req = 1'b0; fault_ack = 1'b0;
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        m_cnt = 0; m_irq = 1'b0; m_err = 1'b0; m_dout = '0;
        @(negedge clk);
        rst = 1'b0;
        compare("R8");
    endtask

    initial begin
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();

        // directed: fill, overflow, ack with fault in same cycle, ack alone
        for (int i = 0; i < D; i++) step(1, 0, W'(16'hA000 + i), 0);
        step(1, 0, 16'hDEAD, 0);              // R4 overflow
        step(0, 0, 16'h0, 0);                 // R6 held
        step(1, 0, 16'hBEEF, 1);              // R6 ack + new fault stays set
        step(0, 0, 16'h0, 1);                 // R6 clear
        step(1, 1, 16'h1111, 0);              // R7 clash at full
        for (int i = 0; i < D; i++) step(0, 1, '0, 0);  // R2 LIFO order
        step(0, 0, 16'h0, 0);                 // R9 hold
        step(0, 1, '0, 0);                    // R5 underflow
        step(0, 0, '0, 1);
        step(1, 1, 16'h2222, 0);              // R7 clash at empty
        step(1, 0, 16'h3333, 0);
        step(0, 0, '0, 0);                    // R9

        // random phases biased towards filling and draining
        for (int ph = 0; ph < 40; ph++) begin
            int bias = (ph % 2 == 0) ? 75 : 25;
            for (int k = 0; k < 60; k++) begin
                int r = $urandom_range(99);
                logic p = (r < bias);
                logic q = !p && ($urandom_range(99) < 80);
                if ($urandom_range(29) == 0) begin p = 1'b1; q = 1'b1; end
                step(p, q, W'($urandom()), ($urandom_range(3) == 0));
            end
            if (ph == 17) do_reset();             // R8 mid-run
        end
        do_reset();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule